// File: doc/BRIEF.md
# Bit-Field Operation Unit

This unit works on a field of arbitrary position and length inside a 32-bit data word. The field's position and length come from an offset and a width. Positions are counted from the most significant bit toward the least significant, and a field that runs past bit 0 continues at bit 31. One opcode picks one of eight operations. Four of them rewrite the field in the destination word: test, clear, set and invert. Two return the field right-justified in a result value, either zero-filled or sign-extended. One writes the low bits of a source register into the field. The last searches the field for its leftmost 1.

Every operation also returns N and Z condition flags. These are computed from the field as it was before the operation. Insert is the exception: its flags are computed from the value being inserted. V and C are always returned cleared. The offset comes from a 5-bit immediate or from a 32-bit signed register value. The width comes from a 5-bit immediate or from the low 5 bits of a register.

One operation is accepted per cycle. Its results appear on the outputs one clock later and stay there until the next accepted operation.

Top module: `bf_unit`

## Requirements
- R1: While reset is asserted and after it is released with no operation issued, `out_valid`, `word_out`, `result_out` and all four flags read 0.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. When `in_valid` is low, `word_out` and `result_out` hold their previous values.
- R3: The field covers the bit positions 31-((off+i) mod 32) for i = 0..width-1, with i = 0 being the field's leftmost bit. A width code of 0 means 32 bits. A register width uses only bits 4:0 of `wid_reg`.
- R4: With `off_sel`=0 the offset is `off_imm` (0..31). With `off_sel`=1 it is `off_reg`, read as a signed 32-bit value, and its value mod 32 sets the position.
- R5: N equals the original field's leftmost bit. Z is 1 if and only if every original field bit is 0. V and C are 0.
- R6: The field in `word_out` is unchanged for op 0 (test), all zeros for op 1 (clear), all ones for op 2 (set), and inverted for op 3 (invert). Bits outside the field are unchanged, and `result_out` is 0.
- R7: Op 4 (unsigned extract) returns the field right-justified with zero fill in `result_out` and leaves `word_out` equal to the destination word.
- R8: Op 5 (signed extract) returns the field right-justified and sign-extended from its leftmost bit to 32 bits.
- R9: Op 6 (insert) writes the low width bits of `src_reg` into the field, with the source's bit width-1 landing in the field's leftmost position. N and Z are computed from those inserted bits, and `result_out` is 0.
- R10: Op 7 (find first one), when the field holds a 1, returns the full offset value plus the index i of the leftmost 1 in the field, computed modulo 2^32. `word_out` equals the destination word.
- R11: Op 7 returns the full offset plus the width when the field holds no 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op | input | 3 | Operation code, 0..7 as listed in the requirements |
| dst_word | input | 32 | Word holding the field |
| src_reg | input | 32 | Insert source value |
| off_sel | input | 1 | 0: immediate offset, 1: register offset |
| off_imm | input | 5 | Immediate offset 0..31 |
| off_reg | input | 32 | Signed register offset |
| wid_sel | input | 1 | 0: immediate width, 1: register width |
| wid_imm | input | 5 | Immediate width code (0 means 32) |
| wid_reg | input | 32 | Register width, low 5 bits used |
| out_valid | output | 1 | Results of the previous accepted operation are present |
| word_out | output | 32 | Updated destination word |
| result_out | output | 32 | Extract or search result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_c | output | 1 | Carry flag, always 0 |

## Verification
The clocked properties sample the data, opcode, offset and width inputs only in cycles where `in_valid` is high. They assume those inputs are at known levels there, and every 3-bit opcode value is a legal operation. The bench drives all inputs on the falling edge and keeps them at defined values from time zero. It never raises `in_valid` while reset is asserted. Its stimulus deliberately includes fields that wrap past bit 0, a negative register offset, a width code of 0, and width registers with junk above bit 4. These place the properties on the mask-count and search-range limits.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    BF_TST  = 3'd0,
    BF_CLR  = 3'd1,
    BF_SET  = 3'd2,
    BF_CHG  = 3'd3,
    BF_EXTU = 3'd4,
    BF_EXTS = 3'd5,
    BF_INS  = 3'd6,
    BF_FFO  = 3'd7
  } bf_op_e;
endpackage

// File: rtl/bf_rotator.sv
module bf_rotator #(
  parameter int unsigned DW   = 32,
  parameter bit          LEFT = 1'b1,
  localparam int unsigned LW  = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] amt,
  output logic [DW-1:0] dout
);
  logic [2*DW-1:0] twice;

  generate
    if (LEFT) begin : g_left
      assign twice = {din, din} << amt;
      assign dout  = twice[2*DW-1:DW];
    end else begin : g_right
      assign twice = {din, din} >> amt;
      assign dout  = twice[DW-1:0];
    end
  endgenerate
endmodule

// File: rtl/bf_lead_count.sv
module bf_lead_count #(
  parameter int unsigned DW = 32,
  localparam int unsigned LW = $clog2(DW)
) (
  input  logic [DW-1:0] vec,
  output logic [LW:0]   cnt
);
  // Highest set bit wins because later iterations overwrite earlier ones.
  always_comb begin
    cnt = (LW+1)'(DW);
    for (int i = 0; i < DW; i++) begin
      if (vec[i]) cnt = (LW+1)'(DW - 1 - i);
    end
  end
endmodule

// File: rtl/bf_unit.sv
module bf_unit
  import bf_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [DW-1:0] dst_word,
  input  logic [DW-1:0] src_reg,
  input  logic          off_sel,
  input  logic [LW-1:0] off_imm,
  input  logic [DW-1:0] off_reg,
  input  logic          wid_sel,
  input  logic [LW-1:0] wid_imm,
  input  logic [DW-1:0] wid_reg,
  output logic          out_valid,
  output logic [DW-1:0] word_out,
  output logic [DW-1:0] result_out,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c
);
  bf_op_e        op_e;
  logic [DW-1:0] off_full;
  logic [LW-1:0] off_lo, wcode, shamt;
  logic [LW:0]   wlen, lead, ffo_pos;
  logic [DW-1:0] rot, mtop, field_top, ins_top, pay_top;
  logic [DW-1:0] wdat, mask, tested;
  logic [DW-1:0] word_nx, res_nx;
  logic          n_nx, z_nx, writes;
  logic          unused_wid_hi;

  logic          valid_q, n_q, z_q;
  logic [DW-1:0] word_q, res_q;

  assign op_e          = bf_op_e'(op);
  assign unused_wid_hi = ^wid_reg[DW-1:LW];

  // Operand selection
  assign off_full = off_sel ? off_reg : DW'(off_imm);
  assign off_lo   = off_full[LW-1:0];
  assign wcode    = wid_sel ? wid_reg[LW-1:0] : wid_imm;
  assign wlen     = (wcode == '0) ? (LW+1)'(DW) : {1'b0, wcode};
  assign shamt    = ~wcode + 1'b1;  // DW - width, modulo DW

  // Bring the field to the top of the word
  bf_rotator #(.DW(DW), .LEFT(1'b1)) i_rot_src (
    .din(dst_word), .amt(off_lo), .dout(rot)
  );

  assign mtop      = {DW{1'b1}} << shamt;
  assign field_top = rot & mtop;
  assign ins_top   = src_reg << shamt;

  always_comb begin
    unique case (op_e)
      BF_CLR:  pay_top = '0;
      BF_SET:  pay_top = '1;
      BF_CHG:  pay_top = ~rot;
      BF_INS:  pay_top = ins_top;
      default: pay_top = rot;
    endcase
  end

  // Return payload and mask to the field's home position
  bf_rotator #(.DW(DW), .LEFT(1'b0)) i_rot_dat (
    .din(pay_top), .amt(off_lo), .dout(wdat)
  );
  bf_rotator #(.DW(DW), .LEFT(1'b0)) i_rot_msk (
    .din(mtop), .amt(off_lo), .dout(mask)
  );

  bf_lead_count #(.DW(DW)) i_lead (
    .vec(field_top), .cnt(lead)
  );

  // Next-state logic
  assign writes  = (op_e == BF_CLR) || (op_e == BF_SET) ||
                   (op_e == BF_CHG) || (op_e == BF_INS);
  assign word_nx = writes ? ((dst_word & ~mask) | (wdat & mask)) : dst_word;
  assign tested  = (op_e == BF_INS) ? ins_top : field_top;
  assign n_nx    = tested[DW-1];
  assign z_nx    = (tested == '0);
  assign ffo_pos = (field_top == '0) ? wlen : lead;

  always_comb begin
    unique case (op_e)
      BF_EXTU: res_nx = rot >> shamt;
      BF_EXTS: res_nx = DW'($signed(rot) >>> shamt);
      BF_FFO:  res_nx = off_full + DW'(ffo_pos);
      default: res_nx = '0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      res_q   <= '0;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        word_q <= word_nx;
        res_q  <= res_nx;
        n_q    <= n_nx;
        z_q    <= z_nx;
      end
    end
  end

  assign out_valid  = valid_q;
  assign word_out   = word_q;
  assign result_out = res_q;
  assign flag_n     = n_q;
  assign flag_z     = z_q;
  assign flag_v     = 1'b0;
  assign flag_c     = 1'b0;

  // Assertions
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(word_out) && $stable(result_out)));
  p_mask_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(mask) == int'(wlen)));
  p_outside_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (((word_nx ^ dst_word) & ~mask) == '0));
  p_extu_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == BF_EXTU) |-> (z_nx == (res_nx == '0)));
  p_exts_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == BF_EXTS) |-> (n_nx == res_nx[DW-1]));
  p_ffo_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == BF_FFO && !z_nx) |-> ((res_nx - off_full) < DW'(wlen)));
endmodule

// File: tb/test_bf_unit.sv
`timescale 1ns/1ps
module test_bf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] dst_word = '0, src_reg = '0, off_reg = '0, wid_reg = '0;
  logic        off_sel = 1'b0, wid_sel = 1'b0;
  logic [4:0]  off_imm = '0, wid_imm = '0;
  logic        out_valid, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] word_out, result_out;
  int          nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  bf_unit i_bf_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .dst_word(dst_word), .src_reg(src_reg),
    .off_sel(off_sel), .off_imm(off_imm), .off_reg(off_reg),
    .wid_sel(wid_sel), .wid_imm(wid_imm), .wid_reg(wid_reg),
    .out_valid(out_valid), .word_out(word_out), .result_out(result_out),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Bit-by-bit model following the requirement text
  task automatic model(input logic [2:0] mop, input logic [31:0] d, input logic [31:0] s,
                       input int off, input int w,
                       output logic [31:0] wo, output logic [31:0] ro,
                       output logic n, output logic z);
    logic [31:0] fv = '0, iv = '0;
    int          first = -1;
    wo = d;
    ro = '0;
    for (int i = 0; i < w; i++) begin
      int pos = 31 - ((off + i) & 31);
      fv[w-1-i] = d[pos];
      iv[w-1-i] = s[w-1-i];
      if (d[pos] && first < 0) first = i;
      case (mop)
        3'd1: wo[pos] = 1'b0;
        3'd2: wo[pos] = 1'b1;
        3'd3: wo[pos] = ~d[pos];
        3'd6: wo[pos] = s[w-1-i];
        default: ;
      endcase
    end
    if (mop == 3'd6) begin
      n = iv[w-1];
      z = (iv == '0);
    end else begin
      n = fv[w-1];
      z = (fv == '0);
    end
    case (mop)
      3'd4: ro = fv;
      3'd5: begin
        ro = fv;
        if (fv[w-1]) for (int k = w; k < 32; k++) ro[k] = 1'b1;
      end
      3'd7: ro = 32'(off + ((first < 0) ? w : first));
      default: ;
    endcase
  endtask

  task automatic apply(input logic [2:0] aop, input logic [31:0] d, input logic [31:0] s,
                       input logic osel, input logic [4:0] oimm, input logic [31:0] oreg,
                       input logic wsel, input logic [4:0] wimm, input logic [31:0] wreg,
                       input string req);
    logic [31:0] ew, er;
    logic        en, ez;
    int          off, w;
    string       freq;
    off  = osel ? int'($signed(oreg)) : int'(oimm);
    w    = wsel ? int'(wreg[4:0]) : int'(wimm);
    if (w == 0) w = 32;
    freq = (aop == 3'd6) ? "R9" : "R5";
    model(aop, d, s, off, w, ew, er, en, ez);
    @(negedge clk);
    op = aop; dst_word = d; src_reg = s;
    off_sel = osel; off_imm = oimm; off_reg = oreg;
    wid_sel = wsel; wid_imm = wimm; wid_reg = wreg;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "out_valid", 32'(out_valid), 32'd1);
    chk(req, "word_out", word_out, ew);
    chk(req, "result_out", result_out, er);
    chk(freq, "flag_n", 32'(flag_n), 32'(en));
    chk(freq, "flag_z", 32'(flag_z), 32'(ez));
    chk("R5", "flag_v", 32'(flag_v), 32'd0);
    chk("R5", "flag_c", 32'(flag_c), 32'd0);
  endtask

  task automatic t_reset;  // R1
    #1;
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "word_out", word_out, 32'd0);
    chk("R1", "result_out", result_out, 32'd0);
    chk("R1", "flags", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
  endtask

  task automatic t_geometry;  // R3 R4 R5
    apply(3'd0, 32'hA5C3_0F96, '0, 1'b0, 5'd13, '0, 1'b0, 5'd12, '0, "R3");
    apply(3'd0, 32'h0000_0000, '0, 1'b0, 5'd4,  '0, 1'b0, 5'd9,  '0, "R5");
    apply(3'd1, 32'hF00F_F00F, '0, 1'b0, 5'd28, '0, 1'b0, 5'd8,  '0, "R3");
    apply(3'd3, 32'h1234_5678, '0, 1'b0, 5'd5,  '0, 1'b0, 5'd0,  '0, "R3");
    apply(3'd4, 32'hDEAD_BEEF, '0, 1'b0, 5'd8,  '0, 1'b1, 5'd0, 32'hFFFF_FFE4, "R3");
    apply(3'd4, 32'h8765_4321, '0, 1'b1, 5'd0, 32'hFFFF_FFFD, 1'b0, 5'd6, '0, "R4");
    apply(3'd4, 32'h8765_4321, '0, 1'b1, 5'd0, 32'h0000_0043, 1'b0, 5'd7, '0, "R4");
  endtask

  task automatic t_modify;  // R6
    apply(3'd1, 32'hFFFF_FFFF, '0, 1'b0, 5'd3,  '0, 1'b0, 5'd10, '0, "R6");
    apply(3'd2, 32'h0000_0000, '0, 1'b0, 5'd30, '0, 1'b0, 5'd5,  '0, "R6");
    apply(3'd3, 32'hAAAA_5555, '0, 1'b0, 5'd16, '0, 1'b0, 5'd16, '0, "R6");
    apply(3'd2, 32'h0F0F_0F0F, '0, 1'b0, 5'd0,  '0, 1'b0, 5'd1,  '0, "R6");
  endtask

  task automatic t_extract;  // R7 R8
    apply(3'd4, 32'hC000_0003, '0, 1'b0, 5'd30, '0, 1'b0, 5'd4,  '0, "R7");
    apply(3'd5, 32'h00F0_0000, '0, 1'b0, 5'd8,  '0, 1'b0, 5'd5,  '0, "R8");
    apply(3'd5, 32'h0070_0000, '0, 1'b0, 5'd8,  '0, 1'b0, 5'd5,  '0, "R8");
    apply(3'd5, 32'h9ABC_DEF0, '0, 1'b0, 5'd0,  '0, 1'b0, 5'd0,  '0, "R8");
  endtask

  task automatic t_insert;  // R9
    apply(3'd6, 32'h0000_0000, 32'hFFFF_FFA5, 1'b0, 5'd12, '0, 1'b0, 5'd8, '0, "R9");
    apply(3'd6, 32'hFFFF_FFFF, 32'h1234_5600, 1'b0, 5'd26, '0, 1'b0, 5'd8, '0, "R9");
    apply(3'd6, 32'h5555_5555, 32'h0000_0005, 1'b1, 5'd0, 32'hFFFF_FFFE, 1'b0, 5'd3, '0, "R9");
  endtask

  task automatic t_ffo;  // R10 R11
    apply(3'd7, 32'h0000_4000, '0, 1'b0, 5'd10, '0, 1'b0, 5'd12, '0, "R10");
    apply(3'd7, 32'h8000_0001, '0, 1'b1, 5'd0, 32'hFFFF_FFF9, 1'b0, 5'd10, '0, "R10");
    apply(3'd7, 32'hFF00_00FF, '0, 1'b0, 5'd10, '0, 1'b0, 5'd6, '0, "R11");
    apply(3'd7, 32'h0000_0000, '0, 1'b1, 5'd0, 32'hFFFF_FFF0, 1'b0, 5'd0, '0, "R11");
  endtask

  task automatic t_hold;  // R2
    logic [31:0] w0, r0;
    apply(3'd5, 32'hF0F0_F0F0, '0, 1'b0, 5'd2, '0, 1'b0, 5'd9, '0, "R8");
    w0 = word_out;
    r0 = result_out;
    dst_word = 32'h1357_9BDF;
    op = 3'd4;
    off_imm = 5'd7;
    @(negedge clk);
    chk("R2", "out_valid idle", 32'(out_valid), 32'd0);
    chk("R2", "word_out held", word_out, w0);
    chk("R2", "result_out held", result_out, r0);
  endtask

  initial begin
    t_reset();
    t_geometry();
    t_modify();
    t_extract();
    t_insert();
    t_ffo();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule